// File: doc/BRIEF.md
# Phase-Shifted Clock Divider

This block divides a fast source clock by a programmable count and sets the high time of the divided clock separately from its period. It also produces three delayed copies of the divided clock: one for the data-output path, one for the data-input path and one for the core. Each copy can be moved later in time in eighth-of-period steps. The largest useful shift is half a period. A larger division factor therefore gives a larger absolute hold margin on the data paths. Alongside the clocks, the block drives a one-cycle enable strobe in the source domain that marks the start of each divided period.

Software programs the block through a write-only register port. Every write lands in a staging copy. The staging copy moves into the active settings only when the period counter wraps, so each divided period runs with one consistent configuration and no runt pulse can appear. If software writes an illegal period value, the write is dropped and a sticky error flag is raised.

Top module: `phase_clkgen`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs go to 0. After reset the active and staged settings are period field 1, high field 0, reference field 1 and all phase codes 0, so `div_clk` divides by 2 with one high cycle.
- R2: `div_clk` repeats every p+1 source cycles, where p is the active period field (write address 0, legal values 1 to 15).
- R3: When the high field h (address 1) is smaller than p, `div_clk` stays high for h+1 source cycles of each period.
- R4: When h is greater than or equal to p, the high time is limited to p cycles, so each period has exactly one low source cycle.
- R5: `clk_en` is high for exactly one source cycle per period, in the cycle where `div_clk` rises.
- R6: A write changes nothing in the running period. The new value takes effect from the first period that starts after the current one ends.
- R7: A write to address 0 with data 0 or data above 15 leaves the period unchanged and sets `cfg_err`. `cfg_err` then stays high until reset.
- R8: Each phase output equals `div_clk` delayed by code × floor((r+1)/8) source cycles. Here r is the reference field (address 2) and the code is the 3-bit phase field: address 3 for `dout_clk`, 4 for `din_clk` and 5 for `core_clk`. Code 0 gives a copy with no delay.
- R9: The three phase fields are independent. With r = p and a division factor of 8 or 16, code 4 shifts that output by exactly half a period.
- R10: Writes to addresses 6 and 7 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 period, 1 high, 2 reference, 3..5 phase codes |
| wr_data | input | 8 | Write data |
| div_clk | output | 1 | Divided clock |
| clk_en | output | 1 | One-cycle strobe at the start of each divided period |
| dout_clk | output | 1 | Phase-shifted clock for data output |
| din_clk | output | 1 | Phase-shifted clock for data input |
| core_clk | output | 1 | Phase-shifted clock for the core |
| cfg_err | output | 1 | Sticky flag for a rejected period write |

## Verification
The assertions check two things on every cycle. The first is that the enable strobe is a single cycle that always coincides with a rising edge of the divided clock. The second is that the error flag is sticky and rises only after an illegal period write. The exact period length, the high time including the limiting case, and the delay of each phase output for a given reference field all depend on the programmed values. These are shown by the bench's vector walk, which measures them. The deferred loading at the period boundary and the rejected writes appear only in the directed scenarios, which count the cycles between strobes around a write.

// File: rtl/pclk_pkg.sv
// Shared constants for the phase clock divider.
// Assumes a 3-bit register select; phase registers are contiguous.
package pclk_pkg;
    localparam int ADDR_W       = 3;
    localparam int NUM_PHASE    = 3;
    localparam int PH_ADDR_BASE = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PERIOD = 3'd0,
        SEL_HIGH   = 3'd1,
        SEL_REF    = 3'd2
    } cfg_sel_e;
endpackage

// File: rtl/pclk_cfg_regs.sv
// Staging and active configuration registers.
// Writes land in staging copies; the active set is refreshed from staging
// only when `load` (period counter wrap) is high. Assumes DATA_W > CNT_W.
module pclk_cfg_regs
    import pclk_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int PH_W   = 3,
    parameter int DATA_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic                              load,
    output logic [CNT_W-1:0]                  p_act,
    output logic [CNT_W-1:0]                  h_act,
    output logic [CNT_W-1:0]                  m_act,
    output logic [NUM_PHASE-1:0][PH_W-1:0]    ph_act,
    output logic                              cfg_err
);
    logic [CNT_W-1:0]               p_stg;
    logic [CNT_W-1:0]               h_stg;
    logic [CNT_W-1:0]               m_stg;
    logic [NUM_PHASE-1:0][PH_W-1:0] ph_stg;
    logic                           p_legal;
    logic                           p_write;

    // Legal period: upper bits clear and low field non-zero.
    always_comb p_legal = (wr_data[DATA_W-1:CNT_W] == '0) && (wr_data[CNT_W-1:0] != '0);
    always_comb p_write = wr_en && (wr_addr == SEL_PERIOD);

    // Capture software writes into the staging copies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_stg  <= CNT_W'(1);
            h_stg  <= '0;
            m_stg  <= CNT_W'(1);
            ph_stg <= '0;
        end else if (wr_en) begin
            if (p_write && p_legal) p_stg <= wr_data[CNT_W-1:0];
            if (wr_addr == SEL_HIGH) h_stg <= wr_data[CNT_W-1:0];
            if (wr_addr == SEL_REF)  m_stg <= wr_data[CNT_W-1:0];
            for (int i = 0; i < NUM_PHASE; i++) begin
                if (wr_addr == ADDR_W'(PH_ADDR_BASE + i)) ph_stg[i] <= wr_data[PH_W-1:0];
            end
        end
    end

    // Copy staging into the active set at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_act  <= CNT_W'(1);
            h_act  <= '0;
            m_act  <= CNT_W'(1);
            ph_act <= '0;
        end else if (load) begin
            p_act  <= p_stg;
            h_act  <= h_stg;
            m_act  <= m_stg;
            ph_act <= ph_stg;
        end
    end

    // Sticky flag for rejected period writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cfg_err <= 1'b0;
        else if (p_write && !p_legal) cfg_err <= 1'b1;
    end
endmodule

// File: rtl/pclk_period_ctr.sv
// Period counter and high-time compare.
// Counts 0..p_act, raises `wrap` in the last cycle, and drives the raw
// (unregistered) divided level. The high time is limited so that at least
// one low cycle remains. Assumes p_act >= 1 (enforced by the register block).
module pclk_period_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] p_act,
    input  logic [CNT_W-1:0] h_act,
    output logic             wrap,
    output logic             raw,
    output logic             en_q
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] h_eff;

    // Limit the high field so the period keeps one low cycle.
    always_comb h_eff = (h_act >= p_act) ? (p_act - CNT_W'(1)) : h_act;
    always_comb wrap  = (cnt == p_act);
    always_comb raw   = (cnt <= h_eff);

    // Advance the period counter, restarting after the last count.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (wrap) cnt <= '0;
        else           cnt <= cnt + CNT_W'(1);
    end

    // Period-start strobe, aligned with the registered divided clock.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= (cnt == '0);
    end
endmodule

// File: rtl/pclk_tap_line.sv
// Delay line for the raw divided level.
// taps[0] is the raw level; taps[k] is that level delayed by k cycles.
// Assumes DEPTH >= 1.
module pclk_tap_line #(
    parameter int DEPTH = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           raw,
    output logic [DEPTH:0] taps
);
    logic [DEPTH-1:0] line;

    // Shift the raw level one stage per source cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) line <= '0;
        else        line <= DEPTH'({line, raw});
    end

    assign taps = {line, raw};
endmodule

// File: rtl/pclk_phase_sel.sv
// Phase tap selector for one shifted clock.
// Delay = code * floor((m_act+1) / 2**PH_W) cycles, picked from the tap line
// and registered, so code 0 matches the registered divided clock.
// Assumes DEPTH covers the largest code times the largest step.
module pclk_phase_sel #(
    parameter int CNT_W = 4,
    parameter int PH_W  = 3,
    parameter int DEPTH = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH:0]   taps,
    input  logic [CNT_W-1:0] m_act,
    input  logic [PH_W-1:0]  code,
    output logic             ph_q
);
    localparam int STEP_W = CNT_W + 1;
    localparam int SH_W   = STEP_W + PH_W;

    logic [STEP_W-1:0] step;
    logic [SH_W-1:0]   shift;
    logic              sel;

    // One step is an eighth (for PH_W = 3) of the reference period, rounded down.
    always_comb step  = (STEP_W'(m_act) + STEP_W'(1)) >> PH_W;
    always_comb shift = SH_W'(code) * SH_W'(step);

    // Pick the tap that matches the requested delay.
    always_comb begin
        sel = taps[0];
        for (int k = 0; k <= DEPTH; k++) begin
            if (shift == SH_W'(k)) sel = taps[k];
        end
    end

    // Register the selected level.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= 1'b0;
        else        ph_q <= sel;
    end
endmodule

// File: rtl/phase_clkgen.sv
// Top of the phase clock divider.
// Divides clk_src by (p+1) with a separate high time, emits a period-start
// strobe, and derives three phase-shifted copies (data out, data in, core).
// All outputs are registered in the clk_src domain.
module phase_clkgen
    import pclk_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int PH_W   = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk_src,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              div_clk,
    output logic              clk_en,
    output logic              dout_clk,
    output logic              din_clk,
    output logic              core_clk,
    output logic              cfg_err
);
    localparam int MAX_STEP  = (2 ** CNT_W) >> PH_W;
    localparam int DEPTH_RAW = ((2 ** PH_W) - 1) * MAX_STEP;
    localparam int DEPTH     = (DEPTH_RAW < 1) ? 1 : DEPTH_RAW;

    logic [CNT_W-1:0]               p_act;
    logic [CNT_W-1:0]               h_act;
    logic [CNT_W-1:0]               m_act;
    logic [NUM_PHASE-1:0][PH_W-1:0] ph_act;
    logic                           wrap;
    logic                           raw;
    logic [DEPTH:0]                 taps;
    logic [NUM_PHASE-1:0]           ph_bus;

    pclk_cfg_regs #(.CNT_W(CNT_W), .PH_W(PH_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk_src),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (wrap),
        .p_act   (p_act),
        .h_act   (h_act),
        .m_act   (m_act),
        .ph_act  (ph_act),
        .cfg_err (cfg_err)
    );

    pclk_period_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk_src),
        .rst_n (rst_n),
        .p_act (p_act),
        .h_act (h_act),
        .wrap  (wrap),
        .raw   (raw),
        .en_q  (clk_en)
    );

    pclk_tap_line #(.DEPTH(DEPTH)) u_taps (
        .clk   (clk_src),
        .rst_n (rst_n),
        .raw   (raw),
        .taps  (taps)
    );

    // One selector per phase output.
    for (genvar i = 0; i < NUM_PHASE; i++) begin : g_phase
        pclk_phase_sel #(.CNT_W(CNT_W), .PH_W(PH_W), .DEPTH(DEPTH)) u_sel (
            .clk   (clk_src),
            .rst_n (rst_n),
            .taps  (taps),
            .m_act (m_act),
            .code  (ph_act[i]),
            .ph_q  (ph_bus[i])
        );
    end

    assign div_clk  = taps[1];
    assign dout_clk = ph_bus[0];
    assign din_clk  = ph_bus[1];
    assign core_clk = ph_bus[2];
endmodule

// File: rtl/phase_clkgen_sva.sv
// Port-level checker for phase_clkgen, attached with bind below.
// Checks the strobe/edge relation and the error flag behaviour.
module phase_clkgen_sva
    import pclk_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int DATA_W = 8
) (
    input logic              clk_src,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              div_clk,
    input logic              clk_en,
    input logic              cfg_err
);
    localparam int P_MAX = (2 ** CNT_W) - 1;

    logic bad_p_wr;
    always_comb bad_p_wr = wr_en && (wr_addr == SEL_PERIOD) &&
                           ((wr_data == '0) || (int'(wr_data) > P_MAX));

    AST_EN_SINGLE: assert property (@(posedge clk_src) disable iff (!rst_n)
        clk_en |=> !clk_en); // R5
    AST_EN_AT_RISE: assert property (@(posedge clk_src) disable iff (!rst_n)
        clk_en |-> $rose(div_clk)); // R5
    AST_RISE_HAS_EN: assert property (@(posedge clk_src) disable iff (!rst_n)
        $rose(div_clk) |-> clk_en); // R5
    AST_ERR_STICKY: assert property (@(posedge clk_src) disable iff (!rst_n)
        cfg_err |=> cfg_err); // R7
    AST_ERR_CAUSE: assert property (@(posedge clk_src) disable iff (!rst_n)
        $rose(cfg_err) |-> $past(bad_p_wr)); // R7
endmodule

bind phase_clkgen phase_clkgen_sva #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_sva (
    .clk_src (clk_src),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .div_clk (div_clk),
    .clk_en  (clk_en),
    .cfg_err (cfg_err)
);

// File: tb/phase_clkgen_tb.sv
// Self-checking bench: vector walk over configurations, then directed tests.
module phase_clkgen_tb;
    localparam int NV  = 8;
    localparam int NC  = 11;
    localparam int REC = 48;
    // Columns: p, h, m, code_dout, code_din, code_core, exp_period, exp_high,
    //          exp_shift_dout, exp_shift_din, exp_shift_core
    localparam int VEC [NV][NC] = '{
        '{ 1,  0,  1, 0, 0, 0,  2,  1, 0,  0, 0},
        '{15,  7, 15, 4, 4, 0, 16,  8, 8,  8, 0},
        '{ 7,  3,  7, 4, 2, 7,  8,  4, 4,  2, 7},
        '{ 9,  4,  9, 3, 1, 5, 10,  5, 3,  1, 5},
        '{ 5,  2,  5, 4, 4, 4,  6,  3, 0,  0, 0},
        '{15, 15, 15, 1, 7, 3, 16, 15, 2, 14, 6},
        '{ 3,  9,  3, 2, 2, 2,  4,  3, 0,  0, 0},
        '{11,  0, 15, 2, 0, 1, 12,  1, 4,  0, 2}
    };

    logic       clk_src = 1'b0;
    logic       rst_n   = 1'b0;
    logic       wr_en   = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       div_clk, clk_en, dout_clk, din_clk, core_clk, cfg_err;

    int n_checks = 0;
    int n_errors = 0;

    logic rec_dc [REC];
    logic rec_en [REC];
    logic rec_ph [3][REC];

    always #2.5 clk_src = ~clk_src;

    phase_clkgen u_dut (
        .clk_src  (clk_src),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .div_clk  (div_clk),
        .clk_en   (clk_en),
        .dout_clk (dout_clk),
        .din_clk  (din_clk),
        .core_clk (core_clk),
        .cfg_err  (cfg_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Write one register; called at a falling edge, returns one cycle later.
    task automatic reg_wr(input int addr, input int data);
        wr_en   = 1'b1;
        wr_addr = 3'(addr);
        wr_data = 8'(data);
        @(negedge clk_src);
        wr_en   = 1'b0;
    endtask

    task automatic wait_en(input int n);
        for (int i = 0; i < n; i++) begin
            do @(negedge clk_src); while (!clk_en);
        end
    endtask

    task automatic record();
        for (int t = 0; t < REC; t++) begin
            @(negedge clk_src);
            rec_dc[t]    = div_clk;
            rec_en[t]    = clk_en;
            rec_ph[0][t] = dout_clk;
            rec_ph[1][t] = din_clk;
            rec_ph[2][t] = core_clk;
        end
    endtask

    // Measure period/high/strobe from the recording and compare.
    task automatic measure(input int exp_per, input int exp_hi, input string hi_req);
        int a = -1;
        int b = -1;
        int hi = 0;
        int extra = 0;
        for (int t = 0; t < REC; t++) begin
            if (rec_en[t]) begin
                if (a < 0) a = t;
                else if (b < 0) b = t;
            end
        end
        check(a > 0 && b > a, "R2", "strobe pair found", b - a, exp_per);
        if (a > 0 && b > a) begin
            for (int t = a; t < b; t++) begin
                if (rec_dc[t]) hi++;
                if (t != a && rec_en[t]) extra++;
            end
            check(b - a == exp_per, "R2", "period", b - a, exp_per);
            check(hi == exp_hi, hi_req, "high cycles", hi, exp_hi);
            check(extra == 0 && rec_dc[a] && !rec_dc[a-1], "R5", "strobe at rise",
                  extra, 0);
        end
    endtask

    task automatic check_shift(input int idx, input int s, input string req);
        int mism = 0;
        for (int t = s; t < REC; t++) begin
            if (rec_ph[idx][t] !== rec_dc[t-s]) mism++;
        end
        check(mism == 0, req, $sformatf("phase %0d delay %0d mismatches", idx, s), mism, 0);
    endtask

    task automatic do_reset();
        @(negedge clk_src);
        rst_n = 1'b0;
        repeat (3) @(negedge clk_src);
        check({div_clk, clk_en, dout_clk, din_clk, core_clk, cfg_err} == 6'b0, "R1",
              "outputs in reset",
              int'({div_clk, clk_en, dout_clk, din_clk, core_clk, cfg_err}), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk_src);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int t0;
        int gap;
        // R1: reset state and default divide-by-2
        do_reset();
        wait_en(3);
        record();
        measure(2, 1, "R1");
        check_shift(0, 0, "R1");

        // Vector walk (R2, R3, R4, R5, R8, R9)
        for (int v = 0; v < NV; v++) begin
            reg_wr(0, VEC[v][0]);
            reg_wr(1, VEC[v][1]);
            reg_wr(2, VEC[v][2]);
            reg_wr(3, VEC[v][3]);
            reg_wr(4, VEC[v][4]);
            reg_wr(5, VEC[v][5]);
            wait_en(3);
            record();
            measure(VEC[v][6], VEC[v][7], (VEC[v][1] >= VEC[v][0]) ? "R4" : "R3");
            for (int j = 0; j < 3; j++)
                check_shift(j, VEC[v][8+j], (VEC[v][3+j] == 4) ? "R9" : "R8");
        end

        // R6: write just after a strobe; running period keeps old length
        reg_wr(0, 15);
        reg_wr(1, 7);
        reg_wr(2, 15);
        wait_en(3);
        reg_wr(0, 3);
        gap = 1;
        while (!clk_en) begin @(negedge clk_src); gap++; end
        check(gap == 16, "R6", "old period completes", gap, 16);
        gap = 0;
        do begin @(negedge clk_src); gap++; end while (!clk_en);
        check(gap == 4, "R6", "new period after boundary", gap, 4);
        wait_en(1);
        record();
        measure(4, 3, "R4");

        // R7: illegal period writes are dropped and flagged
        reg_wr(0, 0);
        check(cfg_err == 1'b1, "R7", "flag after p=0", int'(cfg_err), 1);
        reg_wr(0, 16);
        reg_wr(0, 8'hF3);
        check(cfg_err == 1'b1, "R7", "flag stays set", int'(cfg_err), 1);
        wait_en(3);
        record();
        measure(4, 3, "R7");

        // R10: unused addresses change nothing
        reg_wr(6, 1);
        reg_wr(7, 8'hFF);
        wait_en(3);
        record();
        measure(4, 3, "R10");
        check_shift(0, 0, "R10");

        // R1: reset clears the sticky flag and restores defaults
        do_reset();
        @(negedge clk_src);
        check(cfg_err == 1'b0, "R1", "flag after reset", int'(cfg_err), 0);
        wait_en(3);
        record();
        measure(2, 1, "R1");

        t0 = n_checks;
        if (t0 < 12) $display("note: only %0d checks", t0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule